// File: doc/BRIEF.md
# Cache Throttle Unit (Hit/Miss Budget Guard)

This block watches the hit and miss events of a hardware-managed cache and decides when the cache should be bypassed. The goal is that running with the cache is never slower than running without it. Two saturating event counters track hits and misses. A comparator looks at the values the counters are about to take. As soon as misses outnumber hits, the unit raises a sticky throttle flag. While that flag is high, the surrounding fetch logic sends every instruction and data access straight to main memory.

The counters freeze once the unit has throttled. The flag then stays up until an asynchronous reset or a synchronous clear. Both counter values are brought out so that the decision can be observed.

Top module: `cache_throttle`

## Requirements
- R1: After the active-low reset `rst_ni`, both counters read 0 and `throttle_o` is 0.
- R2: A cycle with `hit_i` high raises `hit_cnt_o` by exactly one, visible after the next rising clock edge.
- R3: A cycle with `miss_i` high raises `miss_cnt_o` by exactly one, visible after the next rising clock edge.
- R4: Each counter is CNT_W bits wide (16 by default) and stops at 2^CNT_W-1 instead of wrapping to 0.
- R5: `throttle_o` rises in the same cycle in which `miss_cnt_o` first shows a value strictly greater than `hit_cnt_o`. It stays 0 while the two counts are equal. A high `throttle_o` means all accesses bypass the cache to main memory.
- R6: Once set, `throttle_o` stays high until `clear_i` or reset, whatever `hit_i` and `miss_i` do.
- R7: While `throttle_o` is high, `hit_i` and `miss_i` are ignored, and both counters hold their values.
- R8: When `hit_i` and `miss_i` are high in the same cycle, both counters advance by one. The throttle decision is made on the two updated values.
- R9: `clear_i` is synchronous. After the edge where it is high, both counters read 0 and `throttle_o` reads 0. It overrides any `hit_i` or `miss_i` in that same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| hit_i | input | 1 | One cache hit in this cycle |
| miss_i | input | 1 | One cache miss in this cycle |
| clear_i | input | 1 | Synchronous clear of counters and throttle |
| throttle_o | output | 1 | Cache bypass flag, sticky |
| hit_cnt_o | output | CNT_W | Current hit count |
| miss_cnt_o | output | CNT_W | Current miss count |

## Verification
A hit and a miss can arrive in the same cycle. The throttle decision must then use both incremented counts, not one new value against one stale value. The bench drives coincident pulses from equal counts, starting from zero and from a non-zero point, and expects both counts to step together with the flag still low. A stale comparison would wrongly throttle there. A clear that coincides with a hit pulse is also checked, and the clear must win.

// File: rtl/cache_throttle_pkg.sv
package cache_throttle_pkg;
  localparam int unsigned CNT_W_DEF = 16;
  localparam int unsigned EV_HIT    = 0;
  localparam int unsigned EV_MISS   = 1;
  localparam int unsigned EV_NUM    = 2;
endpackage

// File: rtl/ct_sat_counter.sv
module ct_sat_counter #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             en_i,
  input  logic             inc_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] cnt_nxt_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clr_i)                               cnt_d = '0;
    else if (en_i && inc_i && cnt_q != CNT_MAX) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign cnt_o     = cnt_q;
  assign cnt_nxt_o = cnt_d;

  AST_CNT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && en_i && inc_i && cnt_q != CNT_MAX) |=> cnt_q == $past(cnt_q) + 1'b1); // R2
  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && cnt_q == CNT_MAX) |=> cnt_q == CNT_MAX); // R4
  AST_CNT_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> cnt_q == '0); // R9
endmodule

// File: rtl/ct_compare.sv
module ct_compare #(
  parameter int unsigned CNT_W = 16
) (
  input  logic [CNT_W-1:0] hit_nxt_i,
  input  logic [CNT_W-1:0] miss_nxt_i,
  output logic             over_o
);
  // strict: equal counts keep the cache enabled
  assign over_o = miss_nxt_i > hit_nxt_i;
endmodule

// File: rtl/cache_throttle.sv
module cache_throttle
  import cache_throttle_pkg::*;
#(
  parameter int unsigned CNT_W = CNT_W_DEF
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             hit_i,
  input  logic             miss_i,
  input  logic             clear_i,
  output logic             throttle_o,
  output logic [CNT_W-1:0] hit_cnt_o,
  output logic [CNT_W-1:0] miss_cnt_o
);
  logic [EV_NUM-1:0]            ev_vec;
  logic [EV_NUM-1:0][CNT_W-1:0] cnt_q;
  logic [EV_NUM-1:0][CNT_W-1:0] cnt_nxt;
  logic                         throttle_q, throttle_d, over;

  assign ev_vec[EV_HIT]  = hit_i;
  assign ev_vec[EV_MISS] = miss_i;

  for (genvar g = 0; g < EV_NUM; g++) begin : g_cnt
    ct_sat_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .clr_i     (clear_i),
      .en_i      (!throttle_q),
      .inc_i     (ev_vec[g]),
      .cnt_o     (cnt_q[g]),
      .cnt_nxt_o (cnt_nxt[g])
    );
  end

  // compare next values so the flag lands with the counts that caused it
  ct_compare #(.CNT_W(CNT_W)) u_cmp (
    .hit_nxt_i  (cnt_nxt[EV_HIT]),
    .miss_nxt_i (cnt_nxt[EV_MISS]),
    .over_o     (over)
  );

  assign throttle_d = clear_i ? 1'b0 : (throttle_q | over);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) throttle_q <= 1'b0;
    else         throttle_q <= throttle_d;
  end

  assign throttle_o = throttle_q;
  assign hit_cnt_o  = cnt_q[EV_HIT];
  assign miss_cnt_o = cnt_q[EV_MISS];

  AST_THR_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(throttle_o) |-> miss_cnt_o > hit_cnt_o); // R5
  AST_THR_NOT_EARLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !throttle_o |-> miss_cnt_o <= hit_cnt_o); // R5
  AST_THR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (throttle_o && !clear_i) |=> throttle_o); // R6
  AST_FREEZE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (throttle_o && !clear_i) |=> ($stable(hit_cnt_o) && $stable(miss_cnt_o))); // R7
  AST_BOTH_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_i && miss_i && !throttle_o && !clear_i && ~hit_cnt_o != '0 && ~miss_cnt_o != '0)
    |=> (hit_cnt_o == $past(hit_cnt_o) + 1'b1 && miss_cnt_o == $past(miss_cnt_o) + 1'b1)); // R8
  AST_CLEAR_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> !throttle_o); // R9
endmodule

// File: tb/cache_throttle_tb_top.sv
module cache_throttle_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int W          = 16;
  localparam int MAXV       = (1 << W) - 1;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         hit_i = 1'b0, miss_i = 1'b0, clear_i = 1'b0;
  logic         throttle_o;
  logic [W-1:0] hit_cnt_o, miss_cnt_o;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  cache_throttle #(.CNT_W(W)) dut_i (
    .clk_i, .rst_ni, .hit_i, .miss_i, .clear_i,
    .throttle_o, .hit_cnt_o, .miss_cnt_o
  );

  task automatic chk(input string req, input string what, input int got, input int exp);
    n_run++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
    end
  endtask

  task automatic state_is(input string req, input int h, input int m, input int t);
    chk(req, "hit_cnt", int'(hit_cnt_o), h);
    chk(req, "miss_cnt", int'(miss_cnt_o), m);
    chk(req, "throttle", int'(throttle_o), t);
  endtask

  // drive one cycle, sample 1 time unit after the edge
  task automatic step(input logic h, input logic m, input logic c);
    @(negedge clk_i);
    hit_i = h; miss_i = m; clear_i = c;
    @(posedge clk_i);
    #1;
    hit_i = 1'b0; miss_i = 1'b0; clear_i = 1'b0;
  endtask

  task automatic t_reset();
    state_is("R1", 0, 0, 0);
  endtask

  task automatic t_count();
    for (int i = 0; i < 5; i++) step(1, 0, 0);
    chk("R2", "hit_cnt after 5 hits", int'(hit_cnt_o), 5);
    for (int i = 0; i < 5; i++) step(0, 1, 0);
    chk("R3", "miss_cnt after 5 misses", int'(miss_cnt_o), 5);
    chk("R5", "no throttle at equal counts", int'(throttle_o), 0);
  endtask

  task automatic t_trip();
    step(0, 1, 0);
    state_is("R5", 5, 6, 1);
  endtask

  task automatic t_frozen();
    for (int i = 0; i < 3; i++) step(1, 0, 0);
    state_is("R7", 5, 6, 1);
    step(0, 1, 0);
    step(1, 1, 0);
    state_is("R6", 5, 6, 1);
  endtask

  task automatic t_clear();
    step(1, 0, 1);
    state_is("R9", 0, 0, 0);
  endtask

  task automatic t_both();
    step(1, 1, 0);
    state_is("R8", 1, 1, 0);
    step(1, 0, 0);
    step(1, 1, 0);
    state_is("R8", 3, 2, 0);
    step(0, 1, 0);
    step(1, 1, 0);
    state_is("R8", 4, 4, 0);
    step(0, 1, 0);
    state_is("R5", 4, 5, 1);
  endtask

  task automatic t_sat();
    step(0, 0, 1);
    @(negedge clk_i);
    hit_i = 1'b1;
    repeat (MAXV + 4) @(posedge clk_i);
    #1;
    hit_i = 1'b0;
    chk("R4", "hit_cnt saturated", int'(hit_cnt_o), MAXV);
    for (int i = 0; i < 3; i++) step(0, 1, 0);
    state_is("R4", MAXV, 3, 0);
  endtask

  task automatic t_reset_mid();
    step(0, 0, 1);
    step(0, 1, 0);
    chk("R5", "throttle from zero", int'(throttle_o), 1);
    @(negedge clk_i);
    rst_ni = 1'b0;
    #1;
    state_is("R1", 0, 0, 0);
    @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  initial begin
    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
    rst_ni = 1'b1;
    t_reset();
    t_count();
    t_trip();
    t_frozen();
    t_clear();
    t_both();
    t_sat();
    t_reset_mid();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk_i);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule